// File: doc/BRIEF.md
# T1 Time-Slot Bit Tap

This block sits behind a T1 framer and carves one signaling channel out of the received serial stream. The framer gives it one line bit per strobe, along with that bit's slot number, its position inside the slot, and a marker for the framing bit. The tap keeps only the bits of one chosen slot out of 24, and only in the frames that the parity mode allows. A mask then picks which of the eight positions in that slot are delivered. What leaves the block is a gated serial bit with a one-clock valid strobe, ready for an HDLC receiver.

Slot, parity mode and mask are loaded into shadow registers on each frame-start pulse. A frame is therefore never cut between two settings. A frame-parity flag is cleared to even by reset and flips on every frame start, so the first frame after reset counts as odd. A small controller has three states. ST_HUNT waits for the first frame start after reset and delivers nothing. ST_PASS marks a frame whose parity is accepted. ST_SKIP marks a frame whose parity is rejected. The controller takes these transitions:

- HUNT to PASS or SKIP, on the first frame start, depending on the parity test.
- PASS or SKIP to PASS or SKIP, on each later frame start, depending on the parity test.
- Any state back to HUNT, on reset.

Top module: `t1_slot_tap`

## Requirements
- R1: After a synchronous reset, tap_valid is 0. No bit is delivered until the first frame_start pulse, whatever the configuration inputs are.
- R2: Only bits whose in_slot equals the latched slot number are delivered. A latched slot number of 24 or more never matches.
- R3: A strobe marked as the framing bit (in_fbit=1) is never delivered.
- R4: Mask bit i enables in_bitpos i, where position 0 is the first bit of the slot on the line. Only enabled positions are delivered, and any combination of them is allowed.
- R5: With an all-zero latched mask, tap_valid never asserts.
- R6: The parity flag resets to even and toggles on each frame_start. The mode encoding is 01 for even frames only, 10 for odd frames only and 11 for both. A frame of rejected parity delivers nothing.
- R7: cfg_slot, cfg_mode and cfg_mask are sampled only in a cycle with frame_start=1. Changing them inside a frame has no effect until the next frame start.
- R8: Each accepted strobe gives exactly one tap_valid pulse, one clock after the strobe cycle. tap_data carries the strobed rx_bit in that same cycle, and tap_data is 0 when tap_valid is 0.
- R9: Mode 00 delivers no bits in any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Received line bit |
| bit_stb | input | 1 | rx_bit and the position inputs are valid this cycle |
| in_fbit | input | 1 | The strobed bit is the framing bit |
| frame_start | input | 1 | First strobe of a frame; must come with bit_stb=1 and in_fbit=1 |
| in_slot | input | 5 | Slot number of the strobed bit (0..23) |
| in_bitpos | input | 3 | Position of the strobed bit inside its slot, 0 first |
| cfg_slot | input | 5 | Slot to extract |
| cfg_mode | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 both |
| cfg_mask | input | 8 | Per-position enable |
| tap_data | output | 1 | Extracted bit |
| tap_valid | output | 1 | tap_data holds an extracted bit |

## Verification
The hardest case to reach is a configuration change in the middle of a frame that only shows up in the following frame. The same goes for parity rejection, which depends on how many frame starts have come since reset. The stimulus feeds whole 193-bit frames with random idle gaps. It changes the configuration inputs at random points inside frames, and it keeps a reference model of the shadow registers and parity flag. Directed frames cover the cases the random stimulus may miss: an empty mask, mode 00, an out-of-range slot, a full mask, and the bits sent before the first frame start.

// File: rtl/t1tap_pkg.sv
package t1tap_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'b00,
        ST_PASS = 2'b01,
        ST_SKIP = 2'b10
    } tap_state_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_EVEN = 2'b01,
        PM_ODD  = 2'b10,
        PM_BOTH = 2'b11
    } parity_mode_e;

endpackage

// File: rtl/t1tap_cfg_shadow.sv
module t1tap_cfg_shadow #(
    parameter int SLOT_W = 5,
    parameter int BITS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] slot_in,
    input  logic [1:0]        mode_in,
    input  logic [BITS-1:0]   mask_in,
    output logic [SLOT_W-1:0] slot_q,
    output logic [1:0]        mode_q,
    output logic [BITS-1:0]   mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            mode_q <= 2'b00;
            mask_q <= '0;
        end else if (load) begin
            slot_q <= slot_in;
            mode_q <= mode_in;
            mask_q <= mask_in;
        end
    end

    // Shadow registers move only on a frame start
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(slot_q) && $stable(mode_q) && $stable(mask_q)));

endmodule

// File: rtl/t1tap_frame_ctrl.sv
module t1tap_frame_ctrl
    import t1tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic [1:0] mode_next,
    output tap_state_e state,
    output logic       parity_odd,
    output logic       frame_open
);

    tap_state_e state_nx;
    logic       parity_nx;
    logic       accept;

    assign parity_nx = ~parity_odd;

    always_comb begin
        unique case (parity_mode_e'(mode_next))
            PM_NONE: accept = 1'b0;
            PM_EVEN: accept = ~parity_nx;
            PM_ODD:  accept = parity_nx;
            PM_BOTH: accept = 1'b1;
            default: accept = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT, ST_PASS, ST_SKIP: begin
                if (frame_start) state_nx = accept ? ST_PASS : ST_SKIP;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            parity_odd <= 1'b0;
        end else begin
            state <= state_nx;
            if (frame_start) parity_odd <= parity_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_PASS: frame_open = 1'b1;
            ST_HUNT, ST_SKIP: frame_open = 1'b0;
            default: frame_open = 1'b0;
        endcase
    end

    assert_parity_flip_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (parity_odd != $past(parity_odd)));

    assert_parity_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(parity_odd));

    assert_none_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_start && mode_next == 2'b00) |=> (state == ST_SKIP));

    assert_hunt_exit_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && !frame_start) |=> (state == ST_HUNT));

endmodule

// File: rtl/t1tap_bit_gate.sv
module t1tap_bit_gate #(
    parameter int SLOTS  = 24,
    parameter int BITS   = 8,
    parameter int SLOT_W = 5,
    parameter int POS_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_open,
    input  logic              bit_stb,
    input  logic              in_fbit,
    input  logic              rx_bit,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [POS_W-1:0]  in_bitpos,
    input  logic [SLOT_W-1:0] slot_q,
    input  logic [BITS-1:0]   mask_q,
    output logic              tap_data,
    output logic              tap_valid
);

    localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(SLOTS);

    logic [BITS-1:0] pos_hit;
    logic            slot_hit;
    logic            take;

    for (genvar i = 0; i < BITS; i++) begin : g_pos
        assign pos_hit[i] = mask_q[i] && (in_bitpos == POS_W'(i));
    end

    assign slot_hit = (in_slot == slot_q) && (slot_q < SLOT_LIMIT);
    assign take     = frame_open && bit_stb && !in_fbit && slot_hit && (|pos_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_valid <= 1'b0;
            tap_data  <= 1'b0;
        end else begin
            tap_valid <= take;
            tap_data  <= take & rx_bit;
        end
    end

    assert_slot_match_R2: assert property (@(posedge clk) disable iff (rst)
        tap_valid |-> $past(in_slot == slot_q));

    assert_no_fbit_R3: assert property (@(posedge clk) disable iff (rst)
        tap_valid |-> $past(bit_stb && !in_fbit));

    assert_mask_bit_R4: assert property (@(posedge clk) disable iff (rst)
        tap_valid |-> $past(mask_q[in_bitpos]));

    assert_empty_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !tap_valid);

    assert_data_follow_R8: assert property (@(posedge clk) disable iff (rst)
        tap_valid |-> (tap_data == $past(rx_bit)));

    assert_quiet_data_R8: assert property (@(posedge clk) disable iff (rst)
        !tap_valid |-> !tap_data);

endmodule

// File: rtl/t1_slot_tap.sv
module t1_slot_tap
    import t1tap_pkg::*;
#(
    parameter int SLOTS = 24,
    parameter int BITS  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       bit_stb,
    input  logic       in_fbit,
    input  logic       frame_start,
    input  logic [4:0] in_slot,
    input  logic [2:0] in_bitpos,
    input  logic [4:0] cfg_slot,
    input  logic [1:0] cfg_mode,
    input  logic [7:0] cfg_mask,
    output logic       tap_data,
    output logic       tap_valid
);

    localparam int SLOT_W = 5;
    localparam int POS_W  = $clog2(BITS);

    logic [SLOT_W-1:0] slot_q;
    logic [1:0]        mode_q;
    logic [BITS-1:0]   mask_q;
    tap_state_e        state;
    logic              parity_odd;
    logic              frame_open;

    t1tap_cfg_shadow #(.SLOT_W(SLOT_W), .BITS(BITS)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_start),
        .slot_in (cfg_slot),
        .mode_in (cfg_mode),
        .mask_in (cfg_mask),
        .slot_q  (slot_q),
        .mode_q  (mode_q),
        .mask_q  (mask_q)
    );

    t1tap_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .mode_next   (cfg_mode),
        .state       (state),
        .parity_odd  (parity_odd),
        .frame_open  (frame_open)
    );

    t1tap_bit_gate #(
        .SLOTS  (SLOTS),
        .BITS   (BITS),
        .SLOT_W (SLOT_W),
        .POS_W  (POS_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .frame_open (frame_open),
        .bit_stb    (bit_stb),
        .in_fbit    (in_fbit),
        .rx_bit     (rx_bit),
        .in_slot    (in_slot),
        .in_bitpos  (in_bitpos),
        .slot_q     (slot_q),
        .mask_q     (mask_q),
        .tap_data   (tap_data),
        .tap_valid  (tap_valid)
    );

    // A delivered bit must come from a frame whose parity was accepted
    assert_parity_gate_R6: assert property (@(posedge clk) disable iff (rst)
        tap_valid |-> $past(state == ST_PASS));

    assert_mode_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS) |-> ((mode_q == 2'b11) ||
                                (mode_q == 2'b01 && !parity_odd) ||
                                (mode_q == 2'b10 && parity_odd)));

endmodule

// File: tb/tb_t1_slot_tap.sv
module tb_t1_slot_tap;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_bit, bit_stb, in_fbit, frame_start;
    logic [4:0] in_slot;
    logic [2:0] in_bitpos;
    logic [4:0] cfg_slot;
    logic [1:0] cfg_mode;
    logic [7:0] cfg_mask;
    logic       tap_data, tap_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    bit       m_started, m_par, m_sel;
    bit [4:0] m_slot;
    bit [1:0] m_mode;
    bit [7:0] m_mask;
    bit       exp_valid, exp_data;
    string    exp_tag;
    int       frame_hits;

    always #(CLK_PERIOD/2) clk = ~clk;

    t1_slot_tap dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_stb(bit_stb),
        .in_fbit(in_fbit), .frame_start(frame_start), .in_slot(in_slot),
        .in_bitpos(in_bitpos), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
        .cfg_mask(cfg_mask), .tap_data(tap_data), .tap_valid(tap_valid)
    );

    function automatic bit mode_ok(input bit [1:0] md, input bit par);
        case (md)
            2'b01:   return !par;
            2'b10:   return par;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string why(input bit stb, input bit fb, input bit [4:0] sl);
        if (!stb)              return "R8";
        if (fb)                return "R3";
        if (!m_started)        return "R1";
        if (m_mode == 2'b00)   return "R9";
        if (!m_sel)            return "R6";
        if (sl != m_slot)      return "R2";
        if (m_mask == 8'h00)   return "R5";
        if (cfg_slot != m_slot || cfg_mask != m_mask) return "R7";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit stb, input bit fb, input bit fs,
                        input bit [4:0] sl, input bit [2:0] pos, input bit d);
        @(negedge clk);
        check(exp_tag, tap_valid, exp_valid);
        check("R8", tap_data, exp_valid & exp_data);
        if (tap_valid) frame_hits++;
        bit_stb = stb; in_fbit = fb; frame_start = fs;
        in_slot = sl; in_bitpos = pos; rx_bit = d;
        if (fs) begin
            m_par = ~m_par;
            m_started = 1'b1;
            m_slot = cfg_slot; m_mode = cfg_mode; m_mask = cfg_mask;
            m_sel = mode_ok(m_mode, m_par);
        end
        exp_tag   = why(stb, fb, sl);
        exp_valid = stb && !fb && m_started && m_sel && (sl == m_slot) && m_mask[pos];
        exp_data  = d;
    endtask

    // one 193-bit frame; cfg must be set before the call; optional mid-frame change
    task automatic frame(input bit gaps, input bit change_mid);
        step(1'b1, 1'b1, 1'b1, 5'd0, 3'd0, 1'($urandom));
        for (int s = 0; s < 24; s++) begin
            if (change_mid && s == 12) begin
                cfg_slot = 5'($urandom_range(0, 23));
                cfg_mode = 2'($urandom);
                cfg_mask = 8'($urandom);
            end
            for (int b = 0; b < 8; b++) begin
                if (gaps && $urandom_range(0, 3) == 0)
                    step(1'b0, 1'($urandom), 1'b0, 5'($urandom), 3'($urandom), 1'($urandom));
                step(1'b1, 1'b0, 1'b0, 5'(s), 3'(b), 1'($urandom));
            end
        end
    endtask

    task automatic set_cfg(input bit [4:0] s, input bit [1:0] m, input bit [7:0] k);
        cfg_slot = s; cfg_mode = m; cfg_mask = k;
    endtask

    task automatic count_frame(input int expect_hits, input string tag);
        frame_hits = 0;
        frame(1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 5'd0, 3'd0, 1'b0);
        n_cmp++;
        if (frame_hits != expect_hits) begin
            n_bad++;
            $display("FAIL %s: actual %0d hits expected %0d", tag, frame_hits, expect_hits);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_71A1));
        rst = 1'b1; bit_stb = 0; in_fbit = 0; frame_start = 0; rx_bit = 0;
        in_slot = 0; in_bitpos = 0;
        set_cfg(5'd3, 2'b11, 8'hFF);
        m_started = 0; m_par = 0; m_sel = 0; m_slot = 0; m_mode = 0; m_mask = 0;
        exp_valid = 0; exp_data = 0; exp_tag = "R1"; frame_hits = 0;
        repeat (4) @(negedge clk);
        check("R1", tap_valid, 1'b0);
        check("R1", tap_data, 1'b0);
        rst = 1'b0;

        // R1: bits before any frame start are dropped even with a matching config
        for (int b = 0; b < 8; b++) step(1'b1, 1'b0, 1'b0, 5'd3, 3'(b), 1'b1);

        // first frame is odd (R6): mode odd, full mask -> 8 bits (R8, R4)
        set_cfg(5'd3, 2'b10, 8'hFF);
        count_frame(8, "R8");
        // second frame even: odd-only rejects (R6)
        count_frame(0, "R6");
        set_cfg(5'd7, 2'b01, 8'h81);         // even-only, frame 3 is odd
        count_frame(0, "R6");
        count_frame(2, "R4");                 // frame 4 even, two positions
        set_cfg(5'd7, 2'b11, 8'h00);
        count_frame(0, "R5");
        set_cfg(5'd7, 2'b00, 8'hFF);
        count_frame(0, "R9");
        set_cfg(5'd24, 2'b11, 8'hFF);
        count_frame(0, "R2");
        set_cfg(5'd23, 2'b11, 8'h10);
        count_frame(1, "R4");
        set_cfg(5'd0, 2'b11, 8'h01);
        count_frame(1, "R3");

        // random frames with gaps and mid-frame configuration changes (R7)
        for (int f = 0; f < 60; f++) begin
            set_cfg(($urandom_range(0, 9) == 0) ? 5'($urandom_range(24, 31))
                                                : 5'($urandom_range(0, 23)),
                    2'($urandom), 8'($urandom));
            frame(1'b1, ($urandom_range(0, 1) == 1));
        end

        // reset in mid-stream returns to hunting (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_started = 0; m_par = 0; m_sel = 0; m_slot = 0; m_mode = 0; m_mask = 0;
        exp_valid = 0; exp_tag = "R1";
        set_cfg(5'd1, 2'b11, 8'hFF);
        for (int b = 0; b < 8; b++) step(1'b1, 1'b0, 1'b0, 5'd1, 3'(b), 1'b1);
        set_cfg(5'd1, 2'b01, 8'hFF);           // first frame after reset is odd
        count_frame(0, "R6");

        repeat (2) step(1'b0, 1'b0, 1'b0, 5'd0, 3'd0, 1'b0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule